// File: doc/BRIEF.md
# Last-Position Truncated-Rice Binarizer

This block turns the column and row coordinates of the last nonzero coefficient in a 4x4 coefficient group into bin strings. Both coordinates arrive together in one cycle, qualified by a valid strobe. A single truncated-Rice datapath codes them one after the other, so the design needs only one binarizer instead of two parallel ones. The Rice parameter is 0 and the largest value is 3. The column bins are emitted first, then the row bins. Each bin carries a tag that names its coordinate.

Output is one bin per clock with a valid flag. A last flag marks the final row bin. All of these bins go to the context-coded class of the arithmetic coder, which sits downstream along with context selection. While a pair is being emitted, the block withdraws its ready signal. The row value waits in a holding register until the column bins have all been sent.

Top module: `lastpos_binarizer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `in_ready` is 1 and `bin_valid` is 0.
- R2: A pair is accepted on a rising edge where `in_valid` and `in_ready` are both 1. The first column bin is presented in the cycle that follows that edge.
- R3: Each coordinate v in 0..3 is coded as v bins of value 1 followed by a single 0. When v is 3 the closing 0 is left out. Examples: 0 gives "0", 1 gives "10", 2 gives "110", 3 gives "111".
- R4: The column bins are all sent before any row bin. `bin_coord` is 0 on column bins and 1 on row bins.
- R5: Exactly one bin is presented per cycle. From the first column bin to the last row bin there is no cycle with `bin_valid` at 0.
- R6: `bin_last` is 1 only on the final row bin.
- R7: `in_ready` is 0 from the accepting edge until the final row bin has been presented. Any `in_valid`, `in_x` or `in_y` values in that window have no effect. The row value used is the one captured at acceptance.
- R8: In the cycle after the final row bin, `bin_valid` is 0 and `in_ready` is 1. If `in_valid` is held high through the busy window, the next pair is accepted on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coordinate pair present |
| in_ready | output | 1 | Block can take a new pair |
| in_x | input | 2 | Column of last nonzero coefficient |
| in_y | input | 2 | Row of last nonzero coefficient |
| bin_valid | output | 1 | A bin is presented this cycle |
| bin_val | output | 1 | Bin value |
| bin_coord | output | 1 | 0 = column bin, 1 = row bin |
| bin_last | output | 1 | Final bin of the pair |

## Verification
The coding function is driven with coordinate pairs that put every value 0..3 on each coordinate. The set includes pairs where both values are at the limit, pairs where both are zero, and mixed pairs. These separate the terminated codes from the truncated code at 3, and they show whether the column and row lengths are tracked independently. During emission, the inputs are changed to unrelated values. This shows that the row value comes from the holding register and not from the live pins. Holding `in_valid` high across a whole pair checks that a back-to-back acceptance happens exactly one cycle after the last bin. A reset in the middle of a pair checks that the block returns to idle with no bins left pending.

// File: rtl/lastpos_pkg.sv
package lastpos_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_COL  = 2'd1,
    PH_ROW  = 2'd2
  } phase_t;
endpackage

// File: rtl/lastpos_tr_unit.sv
// Truncated-Rice (k = 0) bin generator: given the value and the bin index,
// produce the bin and flag the final bin of the string.
module lastpos_tr_unit #(
  parameter int COORD_W = 2
) (
  input  logic [COORD_W-1:0] value,
  input  logic [COORD_W-1:0] idx,
  output logic               bin,
  output logic               final_bin
);
  localparam int CMAX = (1 << COORD_W) - 1;
  localparam logic [COORD_W-1:0] CMAX_V   = COORD_W'(CMAX);
  localparam logic [COORD_W-1:0] LAST_IDX = COORD_W'(CMAX - 1);

  always_comb begin
    bin = (idx < value);
    if (value == CMAX_V) begin
      final_bin = (idx == LAST_IDX);
    end else begin
      final_bin = (idx == value);
    end
  end
endmodule

// File: rtl/lastpos_ctrl.sv
// Sequencer: accepts the pair, keeps the row in a holding register and
// walks the shared unit through column then row.
module lastpos_ctrl
  import lastpos_pkg::*;
#(
  parameter int COORD_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic               final_bin,
  output logic [COORD_W-1:0] cur_value,
  output logic [COORD_W-1:0] cur_idx,
  output phase_t             phase
);
  phase_t             phase_q, phase_d;
  logic [COORD_W-1:0] cur_q, cur_d;
  logic [COORD_W-1:0] idx_q, idx_d;
  logic [COORD_W-1:0] hold_q;
  logic               hold_en;
  logic               step_en;

  always_comb begin
    phase_d = phase_q;
    cur_d   = cur_q;
    idx_d   = idx_q;
    hold_en = 1'b0;
    step_en = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (in_valid) begin
          phase_d = PH_COL;
          cur_d   = in_x;
          idx_d   = '0;
          hold_en = 1'b1;
          step_en = 1'b1;
        end
      end
      PH_COL: begin
        step_en = 1'b1;
        if (final_bin) begin
          phase_d = PH_ROW;
          cur_d   = hold_q;
          idx_d   = '0;
        end else begin
          idx_d = COORD_W'(idx_q + 1'b1);
        end
      end
      PH_ROW: begin
        step_en = 1'b1;
        if (final_bin) begin
          phase_d = PH_IDLE;
          idx_d   = '0;
        end else begin
          idx_d = COORD_W'(idx_q + 1'b1);
        end
      end
      default: begin
        phase_d = PH_IDLE;
        step_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cur_q   <= '0;
      idx_q   <= '0;
    end else if (step_en) begin
      phase_q <= phase_d;
      cur_q   <= cur_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= in_y;
    end
  end

  assign cur_value = cur_q;
  assign cur_idx   = idx_q;
  assign phase     = phase_q;
endmodule

// File: rtl/lastpos_binarizer.sv
module lastpos_binarizer
  import lastpos_pkg::*;
#(
  parameter int COORD_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               bin_valid,
  output logic               bin_val,
  output logic               bin_coord,
  output logic               bin_last
);
  logic [COORD_W-1:0] cur_value;
  logic [COORD_W-1:0] cur_idx;
  logic               final_bin;
  logic               tr_bin;
  phase_t             phase;

  lastpos_ctrl #(.COORD_W(COORD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .in_y      (in_y),
    .final_bin (final_bin),
    .cur_value (cur_value),
    .cur_idx   (cur_idx),
    .phase     (phase)
  );

  lastpos_tr_unit #(.COORD_W(COORD_W)) u_tr (
    .value     (cur_value),
    .idx       (cur_idx),
    .bin       (tr_bin),
    .final_bin (final_bin)
  );

  always_comb begin
    in_ready  = (phase == PH_IDLE);
    bin_valid = (phase == PH_COL) || (phase == PH_ROW);
    bin_coord = (phase == PH_ROW);
    bin_val   = bin_valid && tr_bin;
    bin_last  = (phase == PH_ROW) && final_bin;
  end
endmodule

// File: rtl/lastpos_binarizer_chk.sv
module lastpos_binarizer_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic bin_valid,
  input logic bin_val,
  input logic bin_coord,
  input logic bin_last
);
  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bin_valid |-> !in_ready);
  // R6
  last_on_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bin_last |-> (bin_valid && bin_coord));
  // R2
  first_bin_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (bin_valid && !bin_coord));
  // R8
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bin_last |=> (in_ready && !bin_valid));
  // R4
  row_not_followed_by_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_valid && bin_coord) |=> (!bin_valid || bin_coord));
  // R5
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_valid && !bin_last) |=> bin_valid);
endmodule

bind lastpos_binarizer lastpos_binarizer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .bin_valid (bin_valid),
  .bin_val   (bin_val),
  .bin_coord (bin_coord),
  .bin_last  (bin_last)
);

// File: tb/lastpos_binarizer_test.sv
`timescale 1ns/1ps
module lastpos_binarizer_test;
  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [1:0] in_x;
  logic [1:0] in_y;
  logic       bin_valid;
  logic       bin_val;
  logic       bin_coord;
  logic       bin_last;

  int checks;
  int failures;
  int cycles;
  bit done;

  lastpos_binarizer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .bin_valid(bin_valid), .bin_val(bin_val),
    .bin_coord(bin_coord), .bin_last(bin_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {x, y, xlen, xbits(msb first), ylen, ybits(msb first)}
  localparam int NVEC = 8;
  localparam logic [13:0] VECS [NVEC] = '{
    14'b00_00_01_000_01_000,
    14'b01_10_10_100_11_110,
    14'b11_01_11_111_10_100,
    14'b10_11_11_110_11_111,
    14'b11_11_11_111_11_111,
    14'b00_11_01_000_11_111,
    14'b10_00_11_110_01_000,
    14'b01_01_10_100_10_100
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_bin(input bit v, input bit crd, input bit lst);
    chk(bin_valid == 1'b1, "R5 bin_valid", bin_valid, 1);
    chk(bin_val == v, "R3 bin_val", bin_val, v);
    chk(bin_coord == crd, "R4 bin_coord", bin_coord, crd);
    chk(bin_last == lst, "R6 bin_last", bin_last, lst);
    chk(in_ready == 1'b0, "R7 in_ready busy", in_ready, 0);
  endtask

  task automatic run_vec(input logic [13:0] e, input bit keep_valid);
    logic [1:0] x, y, xl, yl;
    logic [2:0] xb, yb;
    {x, y, xl, xb, yl, yb} = e;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready before accept", in_ready, 1);
    in_valid = 1'b1; in_x = x; in_y = y;
    @(negedge clk);
    in_valid = keep_valid; in_x = ~x; in_y = ~y;
    for (int i = 0; i < int'(xl); i++) begin
      check_bin(xb[2-i], 1'b0, 1'b0);
      @(negedge clk);
      in_x = 2'(i); in_y = 2'(i + 1);
    end
    for (int i = 0; i < int'(yl); i++) begin
      check_bin(yb[2-i], 1'b1, i == int'(yl) - 1);
      @(negedge clk);
    end
    if (!keep_valid) begin
      chk(bin_valid == 1'b0, "R8 idle bin_valid", bin_valid, 0);
      chk(in_ready == 1'b1, "R8 idle in_ready", in_ready, 1);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; cycles = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_x = '0; in_y = '0;
    #1;
    chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    chk(bin_valid == 1'b0, "R1 no bin in reset", bin_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(bin_valid == 1'b0, "R1 no bin after reset", bin_valid, 0);

    for (int k = 0; k < NVEC; k++) run_vec(VECS[k], 1'b0);

    // R8 back-to-back: valid held with new pair (3,0) across busy window
    @(negedge clk);
    in_valid = 1'b1; in_x = 2'd2; in_y = 2'd1;
    @(negedge clk);
    in_x = 2'd3; in_y = 2'd0;
    repeat (5) @(negedge clk);  // 3 column bins + 2 row bins of (2,1)
    chk(in_ready == 1'b1, "R8 ready after last", in_ready, 1);
    chk(bin_valid == 1'b0, "R8 gap after last", bin_valid, 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk(bin_valid == 1'b1 && bin_coord == 1'b0, "R8 next pair accepted", bin_valid, 1);
    chk(bin_val == 1'b1, "R3 next pair first bin", bin_val, 1);
    repeat (3) @(negedge clk);
    chk(bin_coord == 1'b1 && bin_val == 1'b0 && bin_last == 1'b1, "R3 zero row single bin",
        {bin_coord, bin_val, bin_last}, 5);
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 idle again", in_ready, 1);

    // R1 reset during emission
    in_valid = 1'b1; in_x = 2'd3; in_y = 2'd3;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(bin_valid == 1'b0, "R1 mid-pair reset clears bins", bin_valid, 0);
    chk(in_ready == 1'b1, "R1 mid-pair reset ready", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bin_valid == 1'b0, "R1 nothing pending", bin_valid, 0);
    run_vec(VECS[1], 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule